// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block sits in a PCIe root port between the link side and the host CPU. Endpoints raise interrupts by posting a 32-bit memory write to one programmable 64-bit address. The block watches the inbound write stream for that address. When a write lands there while capture is armed, the block treats the write data as a vector number and records it in a pending word. Pending vectors are folded into a single level interrupt for the CPU.

Software programs the block through a small 32-bit register slave. The slave holds the two halves of the capture address, a per-vector enable word, a per-vector mask word and the pending (status) word. Software acknowledges a vector by writing a one to its pending bit. The interrupt line falls only when such a write leaves no vector pending at all.

A window hit is reported on a registered claim output, so the surrounding fabric knows the write was consumed. Inbound reads are never looked at and pass by the block.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After a synchronous reset the interrupt output and claim output are 0, and the address halves, enable, mask and status registers all read back 0.
- R2: Register offset 0x820 holds capture address bits 31:0 and 0x824 holds bits 63:32. A write to either offset replaces only that half and leaves the other half unchanged.
- R3: A read sets the read-valid output and places the addressed register on the read data output in the cycle after the read request. Offset 0x828 is the enable word, 0x82C the mask word and 0x830 the status word. Any other offset reads 0.
- R4: An inbound write is claimed only when all of these hold: the enable word is nonzero, the write address equals the 64-bit capture address exactly, and all four byte enables are 1. The claim output pulses in the following cycle.
- R5: A claimed write of value V, with V below 32, sets status bit V when enable bit V is 1. When enable bit V is 0 the status word is left unchanged.
- R6: A claimed write with a value of 32 or more leaves the status word unchanged.
- R7: The interrupt output is evaluated on each claimed write and is set in the next cycle if any status bit is 1 whose mask bit is 0. Changing the mask alone does not raise it.
- R8: A register write to 0x830 inverts every status bit written as 1 and leaves the bits written as 0 alone.
- R9: The interrupt output clears only after a status write that leaves the whole status word at 0. Setting mask bits, or clearing only some of the pending bits, keeps it high.
- R10: When a claimed write and a status write occur in the same cycle, the toggle is applied first and the captured vector's bit is set afterwards.
- R11: An inbound write that is not claimed leaves the status word and the interrupt output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| in_wr_valid | input | 1 | Inbound posted write valid |
| in_wr_addr | input | 64 | Inbound write address |
| in_wr_data | input | 32 | Inbound write data, the vector number |
| in_wr_be | input | 4 | Inbound write byte enables |
| cap_claim | output | 1 | Registered pulse: the previous inbound write hit the capture window |
| irq | output | 1 | Level interrupt to the host CPU |

## Verification
The bound checker checks on every cycle that:
- a claim only follows a full-width write while the window is armed;
- the interrupt rises only together with a claim;
- the interrupt falls only after a status write that leaves nothing pending;
- the status word holds still when neither a claim nor a status write occurred;
- outside of status writes, no status bit is ever set whose enable bit was 0.

Some behaviour can only be shown by the bench's scenarios. These are the exact address-half merging, the treatment of out-of-range vectors, a mask that blocks the interrupt, and the ordering when a toggle and a capture land in the same cycle. The bench checks them by reading values back through the register slave.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFF_ADDR0 = 12'h820;
  localparam logic [REG_AW-1:0] OFF_EN    = 12'h828;
  localparam logic [REG_AW-1:0] OFF_MSK   = 12'h82C;
  localparam logic [REG_AW-1:0] OFF_ST    = 12'h830;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ADDR,
    SEL_EN,
    SEL_MSK,
    SEL_ST
  } reg_sel_e;
endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] status_q,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] enable_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              st_wr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int HALVES = ADDR_W / DATA_W;
  localparam int STEP   = DATA_W / 8;

  logic [DATA_W-1:0] addr_part [HALVES];
  logic [DATA_W-1:0] rd_mux;

  // Each address half is written on its own and keeps the other intact.
  for (genvar h = 0; h < HALVES; h++) begin : g_addr
    localparam logic [REG_AW-1:0] OFF = OFF_ADDR0 + REG_AW'(h * STEP);
    always_ff @(posedge clk) begin
      if (rst)                            addr_part[h] <= '0;
      else if (reg_wr_en && reg_addr == OFF) addr_part[h] <= reg_wdata;
    end
    assign cap_addr[h*DATA_W +: DATA_W] = addr_part[h];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      mask_q   <= '0;
    end else if (reg_wr_en) begin
      if (reg_addr == OFF_EN)  enable_q <= reg_wdata;
      if (reg_addr == OFF_MSK) mask_q   <= reg_wdata;
    end
  end

  assign st_wr = reg_wr_en && (reg_addr == OFF_ST);

  always_comb begin
    rd_mux = '0;
    for (int h = 0; h < HALVES; h++)
      if (reg_addr == OFF_ADDR0 + REG_AW'(h * STEP)) rd_mux = addr_part[h];
    if (reg_addr == OFF_EN)  rd_mux = enable_q;
    if (reg_addr == OFF_MSK) rd_mux = mask_q;
    if (reg_addr == OFF_ST)  rd_mux = status_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= reg_rd_en;
      if (reg_rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/msi_cap_window.sv
module msi_cap_window #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_wr_valid,
  input  logic [ADDR_W-1:0]   in_wr_addr,
  input  logic [DATA_W-1:0]   in_wr_data,
  input  logic [DATA_W/8-1:0] in_wr_be,
  input  logic [ADDR_W-1:0]   cap_addr,
  input  logic [DATA_W-1:0]   enable_q,
  output logic                hit,
  output logic [DATA_W-1:0]   set_bits,
  output logic                claim_q
);
  localparam int NUM_VEC = DATA_W;

  logic [NUM_VEC-1:0] vec_onehot;

  // Values at or above NUM_VEC match no bit and so select nothing.
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign vec_onehot[v] = (in_wr_data == DATA_W'(v));
  end

  assign hit = in_wr_valid && (&in_wr_be) && (|enable_q) &&
               (in_wr_addr == cap_addr);
  assign set_bits = hit ? (vec_onehot & enable_q) : '0;

  always_ff @(posedge clk) begin
    if (rst) claim_q <= 1'b0;
    else     claim_q <= hit;
  end
endmodule

// File: rtl/msi_cap_status.sv
module msi_cap_status #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [DATA_W-1:0] set_bits,
  input  logic              st_wr,
  input  logic [DATA_W-1:0] st_wdata,
  input  logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] status_q,
  output logic              irq_q
);
  logic [DATA_W-1:0] toggled;
  logic [DATA_W-1:0] status_n;
  logic              irq_n;

  always_comb begin
    toggled  = st_wr ? (status_q ^ st_wdata) : status_q;
    status_n = toggled | set_bits;  // set lands after the toggle
    irq_n    = irq_q;
    if (hit && |(status_n & ~mask_q)) irq_n = 1'b1;
    if (st_wr && status_n == '0)      irq_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      irq_q    <= irq_n;
    end
  end
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr_en,
  input  logic                reg_rd_en,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                reg_rvalid,
  input  logic                in_wr_valid,
  input  logic [ADDR_W-1:0]   in_wr_addr,
  input  logic [DATA_W-1:0]   in_wr_data,
  input  logic [DATA_W/8-1:0] in_wr_be,
  output logic                cap_claim,
  output logic                irq
);
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] enable_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] set_bits;
  logic              st_wr;
  logic              hit;

  msi_cap_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status_q(status_q),
    .cap_addr(cap_addr), .enable_q(enable_q), .mask_q(mask_q),
    .st_wr(st_wr), .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  msi_cap_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_window (
    .clk(clk), .rst(rst),
    .in_wr_valid(in_wr_valid), .in_wr_addr(in_wr_addr),
    .in_wr_data(in_wr_data), .in_wr_be(in_wr_be),
    .cap_addr(cap_addr), .enable_q(enable_q),
    .hit(hit), .set_bits(set_bits), .claim_q(cap_claim)
  );

  msi_cap_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst),
    .hit(hit), .set_bits(set_bits),
    .st_wr(st_wr), .st_wdata(reg_wdata), .mask_q(mask_q),
    .status_q(status_q), .irq_q(irq)
  );
endmodule

// File: rtl/msi_capture_ctrl_chk.sv
module msi_capture_ctrl_chk
  import msi_cap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_wr_en,
  input logic [REG_AW-1:0]   reg_addr,
  input logic                in_wr_valid,
  input logic [DATA_W/8-1:0] in_wr_be,
  input logic                cap_claim,
  input logic                irq,
  input logic [DATA_W-1:0]   status_q,
  input logic [DATA_W-1:0]   enable_q
);
  // R4
  claim_needs_armed_chk: assert property (@(posedge clk) disable iff (rst)
    cap_claim |-> $past(in_wr_valid && (&in_wr_be) && (enable_q != '0)));

  // R7
  irq_rise_on_claim_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> cap_claim);

  // R9
  irq_fall_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> ($past(reg_wr_en && reg_addr == OFF_ST) && status_q == '0));

  // R11
  status_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(reg_wr_en && reg_addr == OFF_ST) && !cap_claim) |-> $stable(status_q));

  // R5
  no_disabled_set_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_wr_en && reg_addr == OFF_ST) |->
      ((status_q & ~$past(status_q) & ~$past(enable_q)) == '0));
endmodule

bind msi_capture_ctrl msi_capture_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .in_wr_valid(in_wr_valid), .in_wr_be(in_wr_be),
  .cap_claim(cap_claim), .irq(irq),
  .status_q(status_q), .enable_q(enable_q)
);

// File: tb/msi_capture_ctrl_bench.sv
`timescale 1ns/1ps
module msi_capture_ctrl_bench;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_IW = 3'd2, OP_CI = 3'd3;
  localparam logic [63:0] CA = 64'h1_FEE0_1000;

  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int N = 47;
  localparam vec_t TBL [N] = '{
    '{OP_WR, 64'h820, 32'hFEE0_0040, 4'hF, 32'h0, 8'd2},        // R2
    '{OP_WR, 64'h824, 32'h1,         4'hF, 32'h0, 8'd2},
    '{OP_RD, 64'h820, 32'h0, 4'hF, 32'hFEE0_0040, 8'd2},
    '{OP_RD, 64'h824, 32'h0, 4'hF, 32'h1,         8'd2},
    '{OP_WR, 64'h820, 32'hFEE0_1000, 4'hF, 32'h0, 8'd2},
    '{OP_RD, 64'h824, 32'h0, 4'hF, 32'h1,         8'd2},        // R2 high kept
    '{OP_RD, 64'h820, 32'h0, 4'hF, 32'hFEE0_1000, 8'd2},
    '{OP_IW, CA, 32'd3, 4'hF, 32'd0, 8'd4},                      // R4 disarmed
    '{OP_RD, 64'h830, 32'h0, 4'hF, 32'h0, 8'd11},               // R11
    '{OP_WR, 64'h828, 32'hFF, 4'hF, 32'h0, 8'd3},               // R3
    '{OP_RD, 64'h828, 32'h0, 4'hF, 32'hFF, 8'd3},
    '{OP_IW, CA, 32'd3, 4'h3, 32'd0, 8'd4},                      // R4 partial be
    '{OP_IW, CA + 64'd4, 32'd3, 4'hF, 32'd0, 8'd4},              // R4 next word
    '{OP_IW, 64'h0_FEE0_1000, 32'd3, 4'hF, 32'd0, 8'd4},         // R4 high half
    '{OP_RD, 64'h830, 32'h0, 4'hF, 32'h0, 8'd11},
    '{OP_CI, 64'h0, 32'h0, 4'hF, 32'd0, 8'd11},
    '{OP_IW, CA, 32'd3, 4'hF, 32'd1, 8'd4},
    '{OP_RD, 64'h830, 32'h0, 4'hF, 32'h8, 8'd5},                // R5
    '{OP_CI, 64'h0, 32'h0, 4'hF, 32'd1, 8'd7},                  // R7
    '{OP_IW, CA, 32'd9, 4'hF, 32'd1, 8'd5},
    '{OP_RD, 64'h830, 32'h0, 4'hF, 32'h8, 8'd5},                // R5 dropped
    '{OP_IW, CA, 32'd40, 4'hF, 32'd1, 8'd6},                    // R6
    '{OP_IW, CA, 32'd32, 4'hF, 32'd1, 8'd6},
    '{OP_RD, 64'h830, 32'h0, 4'hF, 32'h8, 8'd6},
    '{OP_WR, 64'h82C, 32'hFFFF_FFFF, 4'hF, 32'h0, 8'd9},
    '{OP_CI, 64'h0, 32'h0, 4'hF, 32'd1, 8'd9},                  // R9 mask alone
    '{OP_RD, 64'h82C, 32'h0, 4'hF, 32'hFFFF_FFFF, 8'd3},
    '{OP_IW, CA, 32'd5, 4'hF, 32'd1, 8'd5},
    '{OP_WR, 64'h830, 32'h8, 4'hF, 32'h0, 8'd8},
    '{OP_CI, 64'h0, 32'h0, 4'hF, 32'd1, 8'd9},                  // R9 partial
    '{OP_RD, 64'h830, 32'h0, 4'hF, 32'h20, 8'd8},               // R8
    '{OP_WR, 64'h830, 32'h20, 4'hF, 32'h0, 8'd8},
    '{OP_CI, 64'h0, 32'h0, 4'hF, 32'd0, 8'd9},
    '{OP_RD, 64'h830, 32'h0, 4'hF, 32'h0, 8'd8},
    '{OP_IW, CA, 32'd1, 4'hF, 32'd1, 8'd7},
    '{OP_CI, 64'h0, 32'h0, 4'hF, 32'd0, 8'd7},                  // R7 masked
    '{OP_WR, 64'h82C, 32'h0, 4'hF, 32'h0, 8'd7},
    '{OP_CI, 64'h0, 32'h0, 4'hF, 32'd0, 8'd7},                  // R7 unmask alone
    '{OP_IW, CA, 32'd0, 4'hF, 32'd1, 8'd7},
    '{OP_CI, 64'h0, 32'h0, 4'hF, 32'd1, 8'd7},
    '{OP_RD, 64'h830, 32'h0, 4'hF, 32'h3, 8'd5},
    '{OP_WR, 64'h830, 32'h4, 4'hF, 32'h0, 8'd8},
    '{OP_RD, 64'h830, 32'h0, 4'hF, 32'h7, 8'd8},                // R8 sets a 0 bit
    '{OP_CI, 64'h0, 32'h0, 4'hF, 32'd1, 8'd9},
    '{OP_WR, 64'h830, 32'h7, 4'hF, 32'h0, 8'd9},
    '{OP_CI, 64'h0, 32'h0, 4'hF, 32'd0, 8'd9},
    '{OP_RD, 64'h834, 32'h0, 4'hF, 32'h0, 8'd3}                 // R3 unmapped
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        in_wr_valid = 1'b0;
  logic [63:0] in_wr_addr = '0;
  logic [31:0] in_wr_data = '0;
  logic [3:0]  in_wr_be = '0;
  logic        cap_claim, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  msi_capture_ctrl u_msi_capture_ctrl (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .in_wr_valid(in_wr_valid), .in_wr_addr(in_wr_addr),
    .in_wr_data(in_wr_data), .in_wr_be(in_wr_be), .cap_claim(cap_claim), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd_en = 1'b0;
    check(req, {31'd0, reg_rvalid}, 32'd1);
    check(req, reg_rdata, exp);
  endtask

  task automatic in_write(input logic [63:0] a, input logic [31:0] d, input logic [3:0] be,
                          input logic [31:0] exp, input string req);
    @(negedge clk); in_wr_valid = 1'b1; in_wr_addr = a; in_wr_data = d; in_wr_be = be;
    @(negedge clk); in_wr_valid = 1'b0;
    check(req, {31'd0, cap_claim}, exp);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic reset_checks(input string req);
    check(req, {31'd0, irq}, 32'd0);
    check(req, {31'd0, cap_claim}, 32'd0);
    reg_read(12'h820, 32'h0, req);
    reg_read(12'h824, 32'h0, req);
    reg_read(12'h828, 32'h0, req);
    reg_read(12'h82C, 32'h0, req);
    reg_read(12'h830, 32'h0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    reset_checks("R1");

    for (int i = 0; i < N; i++) begin
      string rq;
      rq = $sformatf("R%0d", TBL[i].req);
      case (TBL[i].op)
        OP_WR: reg_write(TBL[i].addr[11:0], TBL[i].data);
        OP_RD: reg_read(TBL[i].addr[11:0], TBL[i].exp, rq);
        OP_IW: in_write(TBL[i].addr, TBL[i].data, TBL[i].be, TBL[i].exp, rq);
        default: begin
          @(negedge clk);
          check(rq, {31'd0, irq}, TBL[i].exp);
        end
      endcase
    end

    // R10: toggle of bit 0 and capture of vector 0 in the same cycle
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 12'h830; reg_wdata = 32'h1;
    in_wr_valid = 1'b1; in_wr_addr = CA; in_wr_data = 32'd0; in_wr_be = 4'hF;
    @(negedge clk);
    reg_wr_en = 1'b0; in_wr_valid = 1'b0;
    check("R10", {31'd0, irq}, 32'd1);
    reg_read(12'h830, 32'h1, "R10");

    // R1: reset mid-run clears everything
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    reset_checks("R1");

    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule